// File: doc/BRIEF.md
# General-Purpose I/O Port with Analog Pin Masking

This block is an eight-pin I/O port that a small processor controls through a register bus. The bus is flat and single-cycle. The processor writes a direction register to choose which pins are inputs and which are driven. It writes an output latch to set the driven levels. It reads back either the latch or the synchronized pin levels. For every pin, the block produces three controls for the pad: a tri-state enable, an output data value, and a weak pull-up enable.

The lowest five pins can also act as analog inputs. While a pin's analog mask bit is set, a port read returns 0 for that pin. A configuration strap is sampled during reset and chooses whether those five pins start as analog or digital. Software can later clear the mask bits through a separate register. There is one active-low pull-up control bit for the whole port, and it only takes effect on pins that are not driven. A peripheral can claim a pin through a per-pin override, and while it does, its output value and enable replace the port's.

The block has no state machine. All of its state is held in registers, and it is written as a register file, a synchronizer and per-pin pad logic.

Top module: `gpio_port`

## Requirements
- R1: Reset is synchronous and active low. During reset, the direction register becomes all ones (every pin an input) and the output latch becomes 0. The pull-up control bit becomes 1, so pull-ups are off. No pin enable is asserted while these reset values are held.
- R2: The analog mask for pins 4..0 loads during reset. It becomes all ones when `strap_analog` is 1 and all zeros when `strap_analog` is 0. A port read (address 2) returns 0 on every pin whose mask bit is 1.
- R3: Pins 7..5 are always digital. A port read returns their synchronized level whatever the strap or the mask holds.
- R4: The direction register is at address 0. A direction bit of 1 makes `pin_oe` 0 for that pin. A direction bit of 0 makes `pin_oe` 1 and drives the latch bit on `pin_out`, as long as the pin is not overridden.
- R5: The output latch is at address 1. Reading it returns the latched value, not the pin level.
- R6: A write to the port address (2) updates the output latch, exactly as a write to address 1 does.
- R7: The pull-up control register is at address 4, and only bit 0 is implemented. When bit 0 is 0, `pin_pu_en` is 1 on exactly those pins whose `pin_oe` is 0. When bit 0 is 1, every `pin_pu_en` is 0.
- R8: The analog mask register is at address 3. Bits 4..0 are stored, where 1 means analog. Bits 7..5 are ignored on write and read as 0. A pin whose mask bit is 0 returns its synchronized level on a port read.
- R9: Pin inputs pass through a two-flop synchronizer. A level change shows up on a port read after exactly two rising clock edges.
- R10: While `alt_en[i]` is 1, the following hold for that pin: `pin_oe[i]` is 1, `pin_out[i]` equals `alt_out[i]`, and `pin_pu_en[i]` is 0.
- R11: Reads from unmapped addresses (5..7) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_analog | input | 1 | Reset-time strap: 1 = low pins start analog |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_out | output | 8 | Pad output data |
| pin_oe | output | 8 | Pad driver enable, 1 = drive |
| pin_pu_en | output | 8 | Weak pull-up enable |
| alt_en | input | 8 | Per-pin peripheral override enable |
| alt_out | input | 8 | Peripheral output data |

## Verification
The bench builds the block with its default parameters: 8 pins, 5 of them analog-capable, and a 2-stage synchronizer. At that size, every one of the 256 pin patterns can be read back under the analog mask and again with it cleared. The bench also sweeps every one of the 256 direction values, checking the enable and data outputs and the pull-up gating for each. Reset is applied with both strap values. The synchronizer's two-edge latency, the override priority, and the ignored upper mask bits each get their own targeted checks.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_DIR  = 3'd0,
        REG_LAT  = 3'd1,
        REG_PIN  = 3'd2,
        REG_ANA  = 3'd3,
        REG_PULL = 3'd4
    } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        chain_q[0] <= async_in;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
        if (STAGES == 2) begin : g_chk
            AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
                sync_out == $past(async_in, 2)); // R9
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int ANA_PINS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_analog,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic [WIDTH-1:0]  pin_sync,
    output logic [WIDTH-1:0]  bus_rdata,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  lat_q,
    output logic              pull_n_q
);
    localparam int DIG_PINS = WIDTH - ANA_PINS;

    logic [ANA_PINS-1:0] amask_q;
    logic [WIDTH-1:0]    amask_full;
    logic [WIDTH-1:0]    pin_view;
    logic                lat_hit;

    assign amask_full = {{DIG_PINS{1'b0}}, amask_q};
    assign pin_view   = pin_sync & ~amask_full;
    assign lat_hit    = bus_we && (bus_addr == REG_LAT || bus_addr == REG_PIN);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q    <= '1;
            lat_q    <= '0;
            pull_n_q <= 1'b1;
            amask_q  <= strap_analog ? '1 : '0;
        end else begin
            if (bus_we && bus_addr == REG_DIR)  dir_q    <= bus_wdata;
            if (lat_hit)                        lat_q    <= bus_wdata;
            if (bus_we && bus_addr == REG_PULL) pull_n_q <= bus_wdata[0];
            if (bus_we && bus_addr == REG_ANA)  amask_q  <= bus_wdata[ANA_PINS-1:0];
        end
    end

    always_comb begin
        case (bus_addr)
            REG_DIR:  bus_rdata = dir_q;
            REG_LAT:  bus_rdata = lat_q;
            REG_PIN:  bus_rdata = pin_view;
            REG_ANA:  bus_rdata = amask_full;
            REG_PULL: bus_rdata = {{(WIDTH-1){1'b0}}, pull_n_q};
            default:  bus_rdata = '0;
        endcase
    end

    AST_LAT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        lat_hit |=> lat_q == $past(bus_wdata)); // R6
    AST_ANALOG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_PIN) |-> ((bus_rdata & amask_full) == '0)); // R2
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > REG_PULL) |-> bus_rdata == '0); // R11
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] lat_q,
    input  logic             pull_n_q,
    input  logic [WIDTH-1:0] alt_en,
    input  logic [WIDTH-1:0] alt_out,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_pu_en
);
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            always_comb begin
                pin_oe[i]    = alt_en[i] | ~dir_q[i];
                pin_out[i]   = alt_en[i] ? alt_out[i] : lat_q[i];
                pin_pu_en[i] = ~pull_n_q & ~pin_oe[i];
            end

            AST_ALT_OWNS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
                alt_en[i] |-> (pin_oe[i] && pin_out[i] == alt_out[i] && !pin_pu_en[i])); // R10
        end
    endgenerate

    AST_PU_OFF_WHEN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu_en & pin_oe) == '0); // R7
    AST_INPUT_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        alt_en == '0 |-> (pin_oe & dir_q) == '0); // R4
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int ANA_PINS    = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_analog,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic [WIDTH-1:0]  pin_pu_en,
    input  logic [WIDTH-1:0]  alt_en,
    input  logic [WIDTH-1:0]  alt_out
);
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] lat_q;
    logic             pull_n_q;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_regs #(.WIDTH(WIDTH), .ANA_PINS(ANA_PINS)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .strap_analog (strap_analog),
        .bus_addr     (bus_addr),
        .bus_we       (bus_we),
        .bus_wdata    (bus_wdata),
        .pin_sync     (pin_sync),
        .bus_rdata    (bus_rdata),
        .dir_q        (dir_q),
        .lat_q        (lat_q),
        .pull_n_q     (pull_n_q)
    );

    gpio_pad_ctl #(.WIDTH(WIDTH)) u_pad (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_q     (dir_q),
        .lat_q     (lat_q),
        .pull_n_q  (pull_n_q),
        .alt_en    (alt_en),
        .alt_out   (alt_out),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .pin_pu_en (pin_pu_en)
    );
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_analog = 1'b1;
    logic [2:0] bus_addr = 3'd0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out, pin_oe, pin_pu_en;
    logic [7:0] alt_en = 8'h00;
    logic [7:0] alt_out = 8'h00;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_port u_dut (
        .clk(clk), .rst_n(rst_n), .strap_analog(strap_analog),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .pin_pu_en(pin_pu_en), .alt_en(alt_en), .alt_out(alt_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0;
        strap_analog = strap;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_pins(input logic [7:0] p);
        @(negedge clk);
        pin_in = p;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            checks++; errors++;
            $display("FAIL watchdog actual %0d expected below 150000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [7:0] v;
        pin_in = 8'hFF;
        do_reset(1'b1);
        @(negedge clk);
        // R1: reset values
        rd(3'd0, v); chk("R1 dir reset", v, 8'hFF);
        rd(3'd1, v); chk("R1 latch reset", v, 8'h00);
        chk("R1 oe reset", pin_oe, 8'h00);
        chk("R1 pull-up off", pin_pu_en, 8'h00);
        rd(3'd4, v); chk("R1 pull ctl reset", v, 8'h01);
        rd(3'd3, v); chk("R2 mask after strap=1", v, 8'h1F);
        rd(3'd5, v); chk("R11 unmapped 5", v, 8'h00);
        rd(3'd7, v); chk("R11 unmapped 7", v, 8'h00);

        // R2, R3: analog masking over all pin patterns
        for (int p = 0; p < 256; p++) begin
            set_pins(p[7:0]);
            rd(3'd2, v); chk("R2 R3 masked read", v, p[7:0] & 8'hE0);
        end

        // R8: upper mask bits ignored, partial mask
        wr(3'd3, 8'hFA);
        rd(3'd3, v); chk("R8 upper bits ignored", v, 8'h1A);
        set_pins(8'hFF);
        rd(3'd2, v); chk("R8 partial mask read", v, 8'hE5);
        wr(3'd3, 8'h00);
        for (int p = 0; p < 256; p++) begin
            set_pins(p[7:0]);
            rd(3'd2, v); chk("R8 digital read", v, p[7:0]);
        end

        // R9: two-edge latency
        set_pins(8'h00);
        bus_addr = 3'd2;
        @(negedge clk); pin_in = 8'hA5;
        @(negedge clk); rd(3'd2, v); chk("R9 after one edge", v, 8'h00);
        @(negedge clk); rd(3'd2, v); chk("R9 after two edges", v, 8'hA5);

        // R4, R7: direction sweep with pull-ups on
        wr(3'd4, 8'h00);
        for (int d = 0; d < 256; d++) begin
            wr(3'd0, d[7:0]);
            wr(3'd1, d[7:0] ^ 8'h5A);
            chk("R4 oe", pin_oe, ~d[7:0]);
            chk("R4 out", pin_out & pin_oe, (d[7:0] ^ 8'h5A) & ~d[7:0]);
            chk("R7 pull-up inputs only", pin_pu_en, d[7:0]);
        end
        wr(3'd4, 8'h01);
        wr(3'd0, 8'hFF);
        chk("R7 pull-up disabled", pin_pu_en, 8'h00);

        // R5, R6: latch readback
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h3C);
        set_pins(8'hC3);
        rd(3'd1, v); chk("R5 latch not pins", v, 8'h3C);
        wr(3'd2, 8'h81);
        rd(3'd1, v); chk("R6 port write to latch", v, 8'h81);
        chk("R6 driven", pin_out, 8'h81);

        // R10: peripheral override
        wr(3'd0, 8'hFF);
        wr(3'd4, 8'h00);
        @(negedge clk);
        alt_en = 8'h0F; alt_out = 8'h05;
        #1;
        chk("R10 oe", pin_oe, 8'h0F);
        chk("R10 out", pin_out & 8'h0F, 8'h05);
        chk("R10 pull-up", pin_pu_en, 8'hF0);
        alt_en = 8'h00;

        // R2: strap cleared gives digital low pins
        pin_in = 8'hA5;
        do_reset(1'b0);
        @(negedge clk); @(negedge clk);
        rd(3'd3, v); chk("R2 mask after strap=0", v, 8'h00);
        rd(3'd2, v); chk("R2 digital after strap=0", v, 8'hA5);

        done = 1;
        finish_run();
    end
endmodule